// File: doc/BRIEF.md
# Power-Down Mode Controller

This block holds an 8-bit standby control register and a small sequencer for the power modes. The processor uses the register to choose what a SLEEP instruction does. It can send the core into plain sleep or into software standby. In software standby the I/O pins either keep their state or go to high impedance. A per-register control also decides whether interrupt requests may end software standby.

The sequencer starts in run mode. A SLEEP strobe moves it to sleep or to software standby, depending on the standby-select bit. An interrupt request always ends sleep. It ends software standby only when the IRQ wake-enable control allows it. Reset ends every mode and restores the register.

While the watchdog runs, the register refuses any attempt to set the standby-select bit or the high-impedance bit. Clearing either bit is always accepted. The block only produces the mode and pad-control signals; clock gating, oscillator settling and the pad drivers sit elsewhere.

Top module: `pwrdn_ctl`

## Requirements
- R1: After reset the read value is 8'h1F: bit 7 (standby select) = 0, bit 6 (port high-impedance select) = 0, bit 0 (IRQ wake-enable control) = 1, and the mode output is run (2'b00).
- R2: Bit 5 always reads 0 and bits 4..1 always read 1, whatever is written. Only bits 7, 6 and 0 are writable.
- R3: In run mode a SLEEP strobe moves the mode to sleep (2'b01) on the next clock if bit 7 is 0, and to software standby (2'b10) if bit 7 is 1.
- R4: A write with data bit 7 = 1 leaves bit 7 unchanged while the watchdog-running input is high. A write with data bit 7 = 0 always clears it.
- R5: A write with data bit 6 = 1 leaves bit 6 unchanged while the watchdog-running input is high. A write with data bit 6 = 0 always clears it.
- R6: The port high-impedance output is 1 exactly while the mode is software standby and bit 6 is 1. It falls on the same clock edge that leaves standby.
- R7: In software standby, any IRQ line high returns the mode to run on the next clock when bit 0 is 0. When bit 0 is 1, IRQs leave the mode in standby.
- R8: In sleep, any IRQ line high returns the mode to run on the next clock, whatever bit 0 holds.
- R9: The SLEEP strobe and register writes are ignored outside run mode.
- R10: Reset leaves software standby and restores the register to 8'h1F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also the reset wake-up |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| wdt_run | input | 1 | High while the watchdog counts |
| sleep_req | input | 1 | SLEEP instruction strobe |
| irq | input | N_IRQ | Interrupt request lines |
| mode | output | 2 | 00 run, 01 sleep, 10 software standby |
| port_hiz | output | 1 | Port high-impedance enable |

## Verification
The bench builds the block with the default of four IRQ lines. Each line is driven alone to end software standby, so a wake path that misses one line is visible. It also exercises both values of the wake-enable control in sleep and in standby, and attempts to set the locked bits with the watchdog running and stopped. SLEEP strobes and writes issued outside run mode are included, as is a reset taken in the middle of standby.

// File: rtl/pwrdn_ctl.sv
module pwrdn_ctl #(
  parameter int N_IRQ = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  input  logic             wdt_run,
  input  logic             sleep_req,
  input  logic [N_IRQ-1:0] irq,
  output logic [1:0]       mode,
  output logic             port_hiz
);

  localparam logic [1:0] M_RUN  = 2'b00;
  localparam logic [1:0] M_SLP  = 2'b01;
  localparam logic [1:0] M_STBY = 2'b10;

  logic stby_sel, hiz_sel, irq_block;
  logic in_run, any_irq, wr_ok;

  assign in_run  = (mode == M_RUN);
  assign any_irq = |irq;
  assign wr_ok   = wr_en && in_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stby_sel  <= 1'b0;
      hiz_sel   <= 1'b0;
      irq_block <= 1'b1;
    end else if (wr_ok) begin
      if (!wr_data[7])   stby_sel <= 1'b0;
      else if (!wdt_run) stby_sel <= 1'b1;
      if (!wr_data[6])   hiz_sel  <= 1'b0;
      else if (!wdt_run) hiz_sel  <= 1'b1;
      irq_block <= wr_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= M_RUN;
    else begin
      case (mode)
        M_RUN:   if (sleep_req) mode <= stby_sel ? M_STBY : M_SLP;
        M_SLP:   if (any_irq) mode <= M_RUN;
        M_STBY:  if (any_irq && !irq_block) mode <= M_RUN;
        default: mode <= M_RUN;
      endcase
    end
  end

  assign rd_data  = {stby_sel, hiz_sel, 1'b0, 4'b1111, irq_block};
  assign port_hiz = (mode == M_STBY) && hiz_sel;

  // R3
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && sleep_req) |=> (mode == ($past(stby_sel) ? M_STBY : M_SLP)));

  // R4
  stby_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdt_run && wr_data[7] && !stby_sel) |=> !stby_sel);

  // R5
  hiz_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdt_run && wr_data[6] && !hiz_sel) |=> !hiz_sel);

  // R7
  stby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_STBY && irq_block) |=> (mode == M_STBY));

  // R8
  sleep_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SLP && any_irq) |=> in_run);

  // R9
  idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_run) |=> $stable(rd_data));

  // R6
  hiz_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_hiz && any_irq && !irq_block) |=> !port_hiz);

endmodule

// File: tb/pwrdn_ctl_tb.sv
module pwrdn_ctl_tb_top;
  localparam int NI = 4;

  logic clk = 0, rst_n = 0, wr_en = 0, wdt_run = 0, sleep_req = 0;
  logic [7:0] wr_data = 0;
  logic [NI-1:0] irq = 0;
  logic [7:0] rd_data;
  logic [1:0] mode;
  logic port_hiz;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";

  int m_mode = 0;
  bit m_b7 = 0, m_b6 = 0, m_b0 = 1;

  always #10 clk = ~clk;

  pwrdn_ctl #(.N_IRQ(NI)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .wdt_run(wdt_run), .sleep_req(sleep_req), .irq(irq), .mode(mode), .port_hiz(port_hiz)
  );

  function automatic logic [7:0] m_rd();
    return {m_b7, m_b6, 1'b0, 4'b1111, m_b0};
  endfunction

  task automatic compare();
    checks++;
    if (rd_data !== m_rd()) begin
      errors++;
      $display("FAIL %s rd_data act=%h exp=%h", tag, rd_data, m_rd());
    end
    checks++;
    if (mode !== 2'(m_mode)) begin
      errors++;
      $display("FAIL %s mode act=%0d exp=%0d", tag, mode, m_mode);
    end
    checks++;
    if (port_hiz !== (m_mode == 2 && m_b6)) begin
      errors++;
      $display("FAIL %s port_hiz act=%0b exp=%0b", tag, port_hiz, (m_mode == 2 && m_b6));
    end
  endtask

  task automatic cyc();
    int nm = m_mode;
    bit n7 = m_b7, n6 = m_b6, n0 = m_b0;
    if (m_mode == 0 && wr_en) begin
      if (!wr_data[7]) n7 = 0; else if (!wdt_run) n7 = 1;
      if (!wr_data[6]) n6 = 0; else if (!wdt_run) n6 = 1;
      n0 = wr_data[0];
    end
    if (m_mode == 0 && sleep_req) nm = m_b7 ? 2 : 1;
    else if (m_mode == 1 && irq != 0) nm = 0;
    else if (m_mode == 2 && irq != 0 && !m_b0) nm = 0;
    @(posedge clk);
    @(negedge clk);
    m_mode = nm; m_b7 = n7; m_b6 = n6; m_b0 = n0;
    compare();
    wr_en = 0; sleep_req = 0; irq = 0;
  endtask

  task automatic wr(input logic [7:0] d, input bit wd, input string t);
    tag = t; wr_data = d; wdt_run = wd; wr_en = 1; cyc(); wdt_run = 0;
  endtask

  task automatic slp(input string t);
    tag = t; sleep_req = 1; cyc();
  endtask

  task automatic do_irq(input logic [NI-1:0] v, input string t);
    tag = t; irq = v; cyc();
  endtask

  task automatic do_reset(input string t);
    tag = t; rst_n = 0; #3;
    m_mode = 0; m_b7 = 0; m_b6 = 0; m_b0 = 1;
    compare();
    @(negedge clk); rst_n = 1;
    cyc();
  endtask

  initial begin
    @(negedge clk);
    do_reset("R1");
    wr(8'h00, 0, "R2");
    wr(8'hFF, 0, "R2");
    wr(8'h20, 0, "R2");
    wr(8'h00, 0, "R4");
    wr(8'h80, 1, "R4");
    wr(8'h40, 1, "R5");
    wr(8'h80, 0, "R4");
    wr(8'h00, 1, "R4");
    wr(8'h40, 0, "R5");
    wr(8'h01, 1, "R5");
    slp("R3");
    slp("R9");
    wr(8'hC0, 0, "R9");
    tag = "R9"; cyc();
    do_irq(4'b0100, "R8");
    wr(8'h00, 0, "R8");
    slp("R3");
    do_irq(4'b0001, "R8");
    wr(8'h81, 0, "R7");
    slp("R3");
    do_irq(4'b1111, "R7");
    slp("R9");
    do_irq(4'b0010, "R7");
    do_reset("R10");
    tag = "R10"; cyc();
    for (int i = 0; i < NI; i++) begin
      wr(8'hC0, 0, "R6");
      slp("R6");
      tag = "R6"; cyc();
      do_irq(NI'(1) << i, "R7");
    end
    wr(8'h80, 0, "R6");
    slp("R6");
    do_irq(4'b1000, "R6");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule